// File: doc/BRIEF.md
# UART Channel Control and Interrupt Logic

This block is the register-side front end of one UART channel. It owns the channel's 8-bit control register, a two-deep receive data queue, a single-byte transmit holding buffer, and three interrupt request lines for an interrupt controller. The serial core signals that a byte has arrived, that a receive error has occurred, or that its shift register can take the next byte. Software uses a small read/write register port. It writes the control register, pops received bytes and writes bytes to send.

Each interrupt line produces a single-cycle pulse when its event occurs. The pulse appears only if its enable bit is set and the channel is enabled. The receive-full pulse can be tied to the first byte or to the second byte in the queue. Clearing the channel enable empties both buffers and makes the block ignore all serial-core events until it is enabled again.

Register port addresses: 0 is the control register. 1 is receive data: a read returns the oldest byte and removes it. 2 is transmit data, write only. 3 reads as zero.

Top module: `uart_ctl_irq`

## Requirements
- R1: After reset the control register reads 0x00, `rx_ready` and `rx_two` are 0, `tx_empty` is 1, and all three interrupt lines are 0.
- R2: In the control register, bit 0 is the channel enable, bit 1 the receive-full threshold, bit 4 the transmit-empty interrupt enable, bit 5 the receive-full interrupt enable and bit 6 the receive-error interrupt enable. Bits 7, 3 and 2 always read 0, and a read returns exactly the written value masked with 0x73.
- R3: Received bytes are read back from address 1 in arrival order, and each read removes one byte. `rx_ready` is 1 when at least one byte is held and `rx_two` is 1 when two are held. A read from an empty queue returns 0x00 and changes nothing.
- R4: With threshold bit 0 and bit 5 set, `irq_rx_full` pulses for exactly one cycle, in the same cycle that `rx_ready` first becomes 1. It does not pulse when the second byte arrives.
- R5: With threshold bit 1 and bit 5 set, `irq_rx_full` pulses for exactly one cycle, in the same cycle that `rx_two` becomes 1. It does not pulse on the first byte.
- R6: A byte that arrives while two are held is discarded: the held bytes and their order are unchanged. It counts as a receive error and pulses `irq_rx_error` when bit 6 is set.
- R7: A pulse on `rx_err` gives a one-cycle `irq_rx_error` pulse in the following cycle when bit 6 is set, and no pulse otherwise.
- R8: A write to address 2 fills the transmit buffer and clears `tx_empty`. When `tx_shift_ready` is high and the buffer is full, `tx_load` is high in that cycle and `tx_data` carries the byte. The buffer is then empty, and `irq_tx_empty` pulses for one cycle if bit 4 is set.
- R9: Writing the control register with bit 0 = 0 empties both buffers at that edge: `rx_ready` = 0, `rx_two` = 0, `tx_empty` = 1, and a receive read returns 0x00.
- R10: While bit 0 is 0, received bytes, receive errors, transmit writes and shift-ready requests are ignored. `tx_load` stays 0 and no interrupt pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rx_byte_valid | input | 1 | Serial core has a received byte |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Serial core reports a framing/parity error |
| tx_shift_ready | input | 1 | Shift register can accept a byte |
| tx_load | output | 1 | Byte moved to the shift register this cycle |
| tx_data | output | 8 | Byte for the shift register |
| rx_ready | output | 1 | At least one received byte held |
| rx_two | output | 1 | Two received bytes held |
| tx_empty | output | 1 | Transmit buffer empty |
| irq_rx_error | output | 1 | Receive error interrupt pulse |
| irq_rx_full | output | 1 | Receive full interrupt pulse |
| irq_tx_empty | output | 1 | Transmit empty interrupt pulse |

## Verification
The bench sweeps every combination of the three interrupt enables and the threshold bit, and all 256 control write values. This sweep catches reserved bits that can be stored and a threshold that fires on the wrong byte. A pulse that stretches to two cycles, or that also fires on the other byte count, shows up as an extra interrupt one cycle later. The bench sends a third byte into a full queue. A design that overwrites or reorders entries on overrun returns the wrong bytes on the next reads. A design that forgets the overrun error loses the error pulse. The bench also disables the channel with data in both buffers and then drives events while it is off. A design without the flush still reports stale data, and a design without event gating moves or queues bytes while it is off.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  localparam int DATA_W = 8;

  // control register bit positions
  localparam int CB_EN      = 0;
  localparam int CB_THR2    = 1;
  localparam int CB_TXE_IE  = 4;
  localparam int CB_RXF_IE  = 5;
  localparam int CB_RXE_IE  = 6;

  localparam logic [DATA_W-1:0] CTRL_MASK = 8'h73;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_RXD  = 2'd1,
    A_TXD  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg
  import uart_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              en_next
);
  logic [DATA_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wdata & CTRL_MASK;
  end

  assign en_next = ctrl_d[CB_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK) == '0);
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [$clog2(DEPTH+1)-1:0] count_q,
  output logic [$clog2(DEPTH+1)-1:0] count_d,
  output logic          overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, rd_ptr_d, wr_ptr, wr_ptr_d;
  logic          pop_ok, push_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    pop_ok   = pop && (count_q != '0);
    push_ok  = push && ((count_q != FULL_CNT) || pop_ok);
    overrun  = push && !push_ok;
    rd_ptr_d = rd_ptr;
    wr_ptr_d = wr_ptr;
    count_d  = count_q;
    if (flush) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      count_d  = '0;
      overrun  = 1'b0;
    end else begin
      if (pop_ok)  rd_ptr_d = nxt(rd_ptr);
      if (push_ok) wr_ptr_d = nxt(wr_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_d = count_q + CW'(1);
        2'b01:   count_d = count_q - CW'(1);
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count_q <= '0;
    end else begin
      rd_ptr  <= rd_ptr_d;
      wr_ptr  <= wr_ptr_d;
      count_q <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && !flush && (wr_ptr == PW'(i))) mem[i] <= din;
    end
  end

  assign head = mem[rd_ptr];

  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && count_q != '0) |=> count_q == $past(count_q) - CW'(1));
  p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && count_q == FULL_CNT) |=> count_q == FULL_CNT && $stable(rd_ptr));
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count_q == '0);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         load,
  output logic         full_q,
  output logic [W-1:0] data_q
);
  logic         full_d, wr_ok;
  logic [W-1:0] data_d;

  always_comb begin
    load   = take && full_q && !flush;
    wr_ok  = wr && (!full_q || load);
    full_d = (full_q && !load) || wr_ok;
    data_d = wr_ok ? din : data_q;
    if (flush) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (wr_ok) data_q <= data_d;
    end
  end

  p_load_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr) |=> !full_q);
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !full_q);
endmodule

// File: rtl/uart_ctl_irq.sv
module uart_ctl_irq
  import uart_ctl_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_byte_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_err,
  input  logic              tx_shift_ready,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_ready,
  output logic              rx_two,
  output logic              tx_empty,
  output logic              irq_rx_error,
  output logic              irq_rx_full,
  output logic              irq_tx_empty
);
  localparam int CW = $clog2(RX_DEPTH+1);
  localparam logic [CW-1:0] RX_FULL = CW'(RX_DEPTH);

  logic [DATA_W-1:0] ctrl_q, rx_head;
  logic              en, en_next, flush, ovr, tx_full;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              sel_ctrl_wr, sel_rx_rd, sel_tx_wr;
  logic              irq_err_d, irq_full_d, irq_txe_d;

  assign sel_ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign sel_rx_rd   = reg_rd && (reg_addr == A_RXD);
  assign sel_tx_wr   = reg_wr && (reg_addr == A_TXD);

  uart_ctl_reg u_ctrl (
    .clk, .rst_n,
    .wr_en   (sel_ctrl_wr),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_q),
    .en_next (en_next)
  );

  assign en    = ctrl_q[CB_EN];
  assign flush = !en_next;

  uart_rx_queue #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk, .rst_n,
    .flush   (flush),
    .push    (rx_byte_valid && en),
    .din     (rx_byte),
    .pop     (sel_rx_rd && en),
    .head    (rx_head),
    .count_q (cnt_q),
    .count_d (cnt_d),
    .overrun (ovr)
  );

  uart_tx_hold #(.W(DATA_W)) u_txh (
    .clk, .rst_n,
    .flush  (flush),
    .wr     (sel_tx_wr && en),
    .din    (reg_wdata),
    .take   (tx_shift_ready && en),
    .load   (tx_load),
    .full_q (tx_full),
    .data_q (tx_data)
  );

  assign rx_ready = (cnt_q != '0);
  assign rx_two   = (cnt_q == RX_FULL);
  assign tx_empty = !tx_full;

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_RXD:   reg_rdata = rx_ready ? rx_head : '0;
      default: reg_rdata = '0;
    endcase
  end

  // interrupt next-state: pulse coincides with the flag change
  always_comb begin
    irq_err_d  = en && ctrl_q[CB_RXE_IE] && (rx_err || ovr);
    irq_txe_d  = en && ctrl_q[CB_TXE_IE] && tx_load;
    irq_full_d = 1'b0;
    if (en && ctrl_q[CB_RXF_IE]) begin
      if (ctrl_q[CB_THR2]) irq_full_d = (cnt_q != RX_FULL) && (cnt_d == RX_FULL);
      else                 irq_full_d = (cnt_q == '0) && (cnt_d != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_rx_error <= 1'b0;
      irq_rx_full  <= 1'b0;
      irq_tx_empty <= 1'b0;
    end else begin
      irq_rx_error <= irq_err_d;
      irq_rx_full  <= irq_full_d;
      irq_tx_empty <= irq_txe_d;
    end
  end

  p_full_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_full |=> !irq_rx_full);
  p_thr1_on_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx_full && $past(ctrl_q[CB_THR2])) |-> rx_two);
  p_err_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_error |-> $past(ctrl_q[CB_RXE_IE]));
  p_txe_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_empty |-> $past(tx_load));
  p_off_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_load);
  p_off_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(irq_rx_error || irq_rx_full || irq_tx_empty));
endmodule

// File: tb/uart_ctl_irq_test.sv
module uart_ctl_irq_test;
  logic       clk = 0, rst_n = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       rx_byte_valid = 0, rx_err = 0, tx_shift_ready = 0;
  logic [7:0] rx_byte = 0, tx_data;
  logic       tx_load, rx_ready, rx_two, tx_empty;
  logic       irq_rx_error, irq_rx_full, irq_tx_empty;
  int         errors = 0, checks = 0;
  bit         done = 0;

  uart_ctl_irq uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a; #1;
    d = reg_rdata;
    step();
    reg_rd = 0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_byte_valid = 1; rx_byte = b;
    step();
    rx_byte_valid = 0;
  endtask

  task automatic irqs(input int e, input int f, input int t, input string tag);
    chk(irq_rx_error, e, {tag, " irq_rx_error"});
    chk(irq_rx_full,  f, {tag, " irq_rx_full"});
    chk(irq_tx_empty, t, {tag, " irq_tx_empty"});
  endtask

  initial begin
    logic [7:0] d;
    #23; rst_n = 1; #1;
    // R1 reset state
    reg_addr = 0; #1;
    chk(reg_rdata, 0, "R1 ctrl");
    chk(rx_ready, 0, "R1 rx_ready");
    chk(rx_two, 0, "R1 rx_two");
    chk(tx_empty, 1, "R1 tx_empty");
    irqs(0, 0, 0, "R1");
    step();

    // R2 every write value
    for (int v = 0; v < 256; v++) begin
      wr_reg(0, 8'(v));
      #1; chk(reg_rdata, v & 8'h73, "R2 readback");
    end
    wr_reg(0, 0);

    // sweep enables and threshold
    for (int c = 0; c < 16; c++) begin
      bit e6 = c[0], e5 = c[1], e4 = c[2], t1 = c[3];
      logic [7:0] cv = {1'b0, e6, e5, e4, 2'b00, t1, 1'b1};
      logic [7:0] a = 8'(c * 7 + 3), b = 8'(c * 11 + 100), x = 8'(c * 5 + 200), tb = 8'(c * 13 + 9);
      wr_reg(0, cv);
      irqs(0, 0, 0, "R7 idle");
      push(a);
      chk(rx_ready, 1, "R3 ready after one");
      chk(rx_two, 0, "R3 two after one");
      irqs(0, int'(e5 && !t1), 0, "R4 first byte");
      step();
      irqs(0, 0, 0, "R4 single cycle");
      push(b);
      chk(rx_two, 1, "R3 two after two");
      irqs(0, int'(e5 && t1), 0, "R5 second byte");
      step();
      irqs(0, 0, 0, "R5 single cycle");
      push(x);
      chk(rx_two, 1, "R6 still two");
      irqs(int'(e6), 0, 0, "R6 overrun");
      rx_err = 1; step(); rx_err = 0;
      irqs(int'(e6), 0, 0, "R7 rx_err");
      step();
      irqs(0, 0, 0, "R7 single cycle");
      rd_reg(1, d); chk(d, a, "R6 first kept");
      chk(rx_two, 0, "R3 two after pop");
      rd_reg(1, d); chk(d, b, "R6 second kept");
      chk(rx_ready, 0, "R3 empty after pops");
      rd_reg(1, d); chk(d, 0, "R3 empty read");
      chk(rx_ready, 0, "R3 empty stays");
      irqs(0, 0, 0, "R3 no irq on pop");
      wr_reg(2, tb);
      chk(tx_empty, 0, "R8 filled");
      tx_shift_ready = 1; #1;
      chk(tx_load, 1, "R8 load");
      chk(tx_data, tb, "R8 data");
      step(); tx_shift_ready = 0; #1;
      chk(tx_empty, 1, "R8 empty");
      irqs(0, 0, int'(e4), "R8 tx irq");
      step();
      irqs(0, 0, 0, "R8 single cycle");
    end

    // R9 flush on disable
    wr_reg(0, 8'h71);
    push(8'h5a); push(8'h6b);
    wr_reg(2, 8'h77);
    chk(rx_two, 1, "R9 pre rx");
    chk(tx_empty, 0, "R9 pre tx");
    wr_reg(0, 8'h70);
    chk(rx_ready, 0, "R9 rx_ready");
    chk(rx_two, 0, "R9 rx_two");
    chk(tx_empty, 1, "R9 tx_empty");
    rd_reg(1, d); chk(d, 0, "R9 rx read");

    // R10 disabled: events ignored
    push(8'h11);
    irqs(0, 0, 0, "R10 push");
    chk(rx_ready, 0, "R10 push ignored");
    rx_err = 1; step(); rx_err = 0;
    step();
    irqs(0, 0, 0, "R10 rx_err");
    wr_reg(2, 8'h22);
    chk(tx_empty, 1, "R10 tx write ignored");
    tx_shift_ready = 1; #1;
    chk(tx_load, 0, "R10 no load");
    step(); tx_shift_ready = 0;
    step();
    irqs(0, 0, 0, "R10 final");
    wr_reg(0, 8'h71);
    chk(rx_ready, 0, "R10 rx empty on enable");
    chk(tx_empty, 1, "R10 tx empty on enable");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule